// File: doc/BRIEF.md
# Stale Translation Sync Tracker

This block decides when a remote request to invalidate address translations may be acknowledged. It keeps a small table of request slots. Each slot records three flags: translation started, complete and discarded. When a sync request arrives, every slot whose translation is under way, and which has neither completed nor been discarded, gets a stale mark. The acknowledgement waits until each of those marks has cleared through a response on its slot. Requests that start after the sync do not hold up the acknowledgement.

The controller has three named states. In `ST_IDLE` it waits for a sync. In `ST_WAIT` it holds the transaction ID of the sync and watches the stale vector. In `ST_SEND` it drives the completion message and holds it until the receiver accepts it. The transitions are:
- `ST_IDLE` goes to `ST_WAIT` when a sync arrives.
- `ST_WAIT` stays in `ST_WAIT` when a further sync arrives, and moves to `ST_SEND` in a cycle with no sync and no stale slot.
- `ST_SEND` goes back to `ST_IDLE` on acceptance, or returns to `ST_WAIT` when a new sync arrives.

A slot is used as follows. An allocate pulse clears all of its flags. A start pulse sets translation-started. A response pulse sets complete. A discard pulse sets discarded. All flags and stale marks are registered, so each takes effect at the next rising edge.

Top module: `stale_sync_tracker`

## Requirements
- R1: After reset `stale_mask` is all zero, and `busy` and `done_vld` are both 0.
- R2: A sync accepted at a rising edge sets bit i of `stale_mask` at that same edge for every slot i that has translation-started set and has neither complete nor discarded set. Bit i of `stale_mask` belongs to slot index i.
- R3: At a sync, a slot that was never started, is already complete, or is already discarded keeps its `stale_mask` bit at 0.
- R4: A response pulse on a slot clears that slot's stale bit at the same edge. A discard pulse leaves the stale bit set.
- R5: `done_vld` is only ever high while `stale_mask` is all zero. It rises one edge after a cycle in `ST_WAIT` that has no sync and an all-zero stale vector.
- R6: While `done_rdy` is low, `done_vld` stays high and `done_txn` stays unchanged. At the edge where `done_vld` and `done_rdy` are both high, the block returns to idle: `done_vld` and `busy` fall.
- R7: `done_txn` carries the transaction ID of the most recent sync accepted.
- R8: Slots allocated or started after a sync are never marked stale by that sync and do not delay its completion.
- R9: A second sync while waiting marks again the slots that qualify and replaces the held ID. Only one completion handshake results.
- R10: A sync that arrives while the completion is offered but not yet accepted withdraws the offer. The block waits again under the new ID.
- R11: `busy` is high from the edge that accepts a sync until the edge that completes the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocate a slot and clear its flags |
| alloc_idx | input | IDX_W | Slot to allocate |
| start_vld | input | 1 | Translation of a slot has started |
| start_idx | input | IDX_W | Slot whose translation started |
| resp_vld | input | 1 | Response received, slot becomes complete |
| resp_idx | input | IDX_W | Slot that got its response |
| disc_vld | input | 1 | Slot's request is discarded |
| disc_idx | input | IDX_W | Slot being discarded |
| sync_vld | input | 1 | Remote translation sync request |
| sync_txn | input | TXN_W | Transaction ID of the sync |
| done_rdy | input | 1 | Receiver accepts the completion message |
| done_vld | output | 1 | Completion message offered |
| done_txn | output | TXN_W | Transaction ID carried by the completion |
| busy | output | 1 | A sync is pending |
| stale_mask | output | NUM_SLOTS | Per-slot stale marks |

## Verification
The properties assume that the environment pulses at most one allocate, start, response and discard per cycle. They also assume that an allocate never targets a slot in the same cycle as any other event on that slot, and that a slot gets a response only after its translation has started. The directed tests keep to these rules: each task drives a single event per cycle on distinct slots, and each response follows the start of the same slot. The tests place syncs in idle, during the wait and during the offer, so that every transition of the controller is exercised.

// File: rtl/stsync_pkg.sv
package stsync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } sync_state_e;
endpackage

// File: rtl/stsync_slot_table.sv
module stsync_slot_table #(
    parameter int NUM_SLOTS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_vld,
    input  logic [IDX_W-1:0]     alloc_idx,
    input  logic                 start_vld,
    input  logic [IDX_W-1:0]     start_idx,
    input  logic                 resp_vld,
    input  logic [IDX_W-1:0]     resp_idx,
    input  logic                 disc_vld,
    input  logic [IDX_W-1:0]     disc_idx,
    input  logic                 mark_req,
    output logic [NUM_SLOTS-1:0] stale_mask
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic started_q, complete_q, discarded_q, stale_q;
        logic alloc_hit, start_hit, resp_hit, disc_hit, in_flight;

        assign alloc_hit = alloc_vld && (alloc_idx == IDX_W'(g));
        assign start_hit = start_vld && (start_idx == IDX_W'(g));
        assign resp_hit  = resp_vld  && (resp_idx  == IDX_W'(g));
        assign disc_hit  = disc_vld  && (disc_idx  == IDX_W'(g));
        assign in_flight = started_q && !complete_q && !discarded_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                started_q   <= 1'b0;
                complete_q  <= 1'b0;
                discarded_q <= 1'b0;
                stale_q     <= 1'b0;
            end else begin
                if (alloc_hit) begin
                    started_q   <= 1'b0;
                    complete_q  <= 1'b0;
                    discarded_q <= 1'b0;
                end
                if (start_hit) started_q   <= 1'b1;
                if (resp_hit)  complete_q  <= 1'b1;
                if (disc_hit)  discarded_q <= 1'b1;
                // a response always wins over a fresh mark
                if (resp_hit || alloc_hit)
                    stale_q <= 1'b0;
                else if (mark_req && in_flight)
                    stale_q <= 1'b1;
            end
        end

        assign stale_mask[g] = stale_q;
    end
endmodule

// File: rtl/stsync_fsm.sv
module stsync_fsm
    import stsync_pkg::*;
#(
    parameter int TXN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_vld,
    input  logic [TXN_W-1:0] sync_txn,
    input  logic             any_stale,
    input  logic             done_rdy,
    output logic             mark_req,
    output logic             busy,
    output logic             done_vld,
    output logic [TXN_W-1:0] done_txn
);
    sync_state_e state_q, state_d;
    logic [TXN_W-1:0] txn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sync_vld) state_d = ST_WAIT;
            ST_WAIT: if (!sync_vld && !any_stale) state_d = ST_SEND;
            ST_SEND: begin
                if (sync_vld)      state_d = ST_WAIT;
                else if (done_rdy) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            txn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (sync_vld) txn_q <= sync_txn;
        end
    end

    always_comb begin
        mark_req = sync_vld;
        busy     = (state_q != ST_IDLE);
        done_vld = (state_q == ST_SEND);
        done_txn = txn_q;
    end
endmodule

// File: rtl/stale_sync_tracker.sv
module stale_sync_tracker #(
    parameter int NUM_SLOTS = 8,
    parameter int TXN_W     = 16,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_vld,
    input  logic [IDX_W-1:0]     alloc_idx,
    input  logic                 start_vld,
    input  logic [IDX_W-1:0]     start_idx,
    input  logic                 resp_vld,
    input  logic [IDX_W-1:0]     resp_idx,
    input  logic                 disc_vld,
    input  logic [IDX_W-1:0]     disc_idx,
    input  logic                 sync_vld,
    input  logic [TXN_W-1:0]     sync_txn,
    input  logic                 done_rdy,
    output logic                 done_vld,
    output logic [TXN_W-1:0]     done_txn,
    output logic                 busy,
    output logic [NUM_SLOTS-1:0] stale_mask
);
    logic mark_req;

    stsync_slot_table #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_vld  (alloc_vld),
        .alloc_idx  (alloc_idx),
        .start_vld  (start_vld),
        .start_idx  (start_idx),
        .resp_vld   (resp_vld),
        .resp_idx   (resp_idx),
        .disc_vld   (disc_vld),
        .disc_idx   (disc_idx),
        .mark_req   (mark_req),
        .stale_mask (stale_mask)
    );

    stsync_fsm #(.TXN_W(TXN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_vld  (sync_vld),
        .sync_txn  (sync_txn),
        .any_stale (|stale_mask),
        .done_rdy  (done_rdy),
        .mark_req  (mark_req),
        .busy      (busy),
        .done_vld  (done_vld),
        .done_txn  (done_txn)
    );
endmodule

// File: rtl/stale_sync_tracker_chk.sv
module stale_sync_tracker_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int TXN_W     = 16,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_vld,
    input logic                 resp_vld,
    input logic [IDX_W-1:0]     resp_idx,
    input logic                 done_rdy,
    input logic                 done_vld,
    input logic [TXN_W-1:0]     done_txn,
    input logic                 busy,
    input logic [NUM_SLOTS-1:0] stale_mask
);
    p_stale_clears_on_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |=> (stale_mask[$past(resp_idx)] == 1'b0));

    p_no_done_while_stale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |-> (stale_mask == '0));

    p_no_growth_without_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_vld |=> ($countones(stale_mask) <= $countones($past(stale_mask))));

    p_offer_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && !done_rdy && !sync_vld) |=> (done_vld && $stable(done_txn)));

    p_release_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && done_rdy && !sync_vld) |=> (!done_vld && !busy));

    p_busy_after_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_vld |=> (busy && !done_vld));

    p_done_implies_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |-> busy);
endmodule

bind stale_sync_tracker stale_sync_tracker_chk #(
    .NUM_SLOTS(NUM_SLOTS), .TXN_W(TXN_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_vld(sync_vld), .resp_vld(resp_vld),
    .resp_idx(resp_idx), .done_rdy(done_rdy), .done_vld(done_vld),
    .done_txn(done_txn), .busy(busy), .stale_mask(stale_mask)
);

// File: tb/stale_sync_tracker_tb_top.sv
module stale_sync_tracker_tb_top;
    localparam int NS = 8;
    localparam int TW = 16;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_vld = 0, start_vld = 0, resp_vld = 0, disc_vld = 0, sync_vld = 0, done_rdy = 0;
    logic [IW-1:0] alloc_idx = '0, start_idx = '0, resp_idx = '0, disc_idx = '0;
    logic [TW-1:0] sync_txn = '0;
    logic done_vld, busy;
    logic [TW-1:0] done_txn;
    logic [NS-1:0] stale_mask;

    int checks = 0;
    int fails = 0;
    int accepts = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    stale_sync_tracker #(.NUM_SLOTS(NS), .TXN_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
        .start_vld(start_vld), .start_idx(start_idx),
        .resp_vld(resp_vld), .resp_idx(resp_idx),
        .disc_vld(disc_vld), .disc_idx(disc_idx),
        .sync_vld(sync_vld), .sync_txn(sync_txn),
        .done_rdy(done_rdy), .done_vld(done_vld), .done_txn(done_txn),
        .busy(busy), .stale_mask(stale_mask)
    );

    always @(posedge clk) if (rst_n && done_vld && done_rdy) accepts <= accepts + 1;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(int i);
        alloc_vld = 1; alloc_idx = IW'(i); tick(); alloc_vld = 0;
    endtask
    task automatic do_start(int i);
        start_vld = 1; start_idx = IW'(i); tick(); start_vld = 0;
    endtask
    task automatic do_resp(int i);
        resp_vld = 1; resp_idx = IW'(i); tick(); resp_vld = 0;
    endtask
    task automatic do_disc(int i);
        disc_vld = 1; disc_idx = IW'(i); tick(); disc_vld = 0;
    endtask
    task automatic do_sync(int t);
        sync_vld = 1; sync_txn = TW'(t); tick(); sync_vld = 0;
    endtask

    task automatic t_reset();
        chk("R1", "stale_mask", stale_mask, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done_vld", done_vld, 0);
    endtask

    task automatic t_marking_and_drain();
        do_alloc(0);
        do_alloc(1); do_start(1);
        do_alloc(2); do_start(2); do_resp(2);
        do_alloc(3); do_start(3); do_disc(3);
        do_alloc(4); do_start(4);
        do_sync(16'h11);
        chk("R2", "stale after sync", stale_mask, 8'b0001_0010);
        chk("R3", "unstarted/complete/discarded unmarked", stale_mask & 8'b0000_1101, 0);
        chk("R11", "busy after sync", busy, 1);
        do_alloc(5); do_start(5);
        chk("R8", "later slot unmarked", stale_mask, 8'b0001_0010);
        do_disc(4);
        chk("R4", "discard keeps stale", stale_mask, 8'b0001_0010);
        do_resp(1);
        chk("R4", "resp clears bit1", stale_mask, 8'b0001_0000);
        chk("R5", "no done while stale", done_vld, 0);
        do_resp(4);
        chk("R4", "resp clears bit4", stale_mask, 0);
        chk("R5", "done not yet", done_vld, 0);
        tick();
        chk("R5", "done after drain", done_vld, 1);
        chk("R8", "slot5 in flight did not delay", done_vld, 1);
        chk("R7", "done_txn", done_txn, 16'h11);
        for (int k = 0; k < 3; k++) tick();
        chk("R6", "offer held", done_vld, 1);
        chk("R6", "txn stable", done_txn, 16'h11);
        done_rdy = 1; tick(); done_rdy = 0;
        chk("R6", "done falls after accept", done_vld, 0);
        chk("R11", "busy falls after accept", busy, 0);
        do_resp(5);
    endtask

    task automatic t_nothing_stale();
        done_rdy = 1;
        do_sync(16'h22);
        chk("R2", "no qualifying slot", stale_mask, 0);
        chk("R5", "done not at sync edge", done_vld, 0);
        chk("R11", "busy", busy, 1);
        done_rdy = 0;
        tick();
        chk("R5", "done one edge later", done_vld, 1);
        chk("R7", "txn 22", done_txn, 16'h22);
        done_rdy = 1; tick(); done_rdy = 0;
        chk("R6", "idle after accept", busy, 0);
    endtask

    task automatic t_resync_wait();
        int base;
        base = accepts;
        do_alloc(6); do_start(6);
        do_sync(16'h0A);
        chk("R2", "slot6 marked", stale_mask, 8'b0100_0000);
        do_alloc(7); do_start(7);
        do_sync(16'h0B);
        chk("R9", "remark adds slot7", stale_mask, 8'b1100_0000);
        do_resp(6);
        chk("R9", "slot7 still stale", stale_mask, 8'b1000_0000);
        do_resp(7);
        tick();
        chk("R9", "done after both", done_vld, 1);
        chk("R9", "latest txn", done_txn, 16'h0B);
        done_rdy = 1; tick(); done_rdy = 0;
        for (int k = 0; k < 3; k++) tick();
        chk("R9", "single handshake", accepts - base, 1);
        chk("R9", "idle", busy, 0);
    endtask

    task automatic t_sync_during_send();
        do_alloc(0);
        do_sync(16'h0C);
        do_start(0);
        chk("R5", "offer up", done_vld, 1);
        chk("R7", "txn 0C", done_txn, 16'h0C);
        do_sync(16'h0D);
        chk("R10", "offer withdrawn", done_vld, 0);
        chk("R10", "still busy", busy, 1);
        chk("R10", "slot0 marked", stale_mask, 8'b0000_0001);
        do_resp(0);
        tick();
        chk("R10", "offer again", done_vld, 1);
        chk("R10", "new txn", done_txn, 16'h0D);
        done_rdy = 1; tick(); done_rdy = 0;
        chk("R6", "idle", busy, 0);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_marking_and_drain();
        t_nothing_stale();
        t_resync_wait();
        t_sync_during_send();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule